// File: doc/BRIEF.md
# Direct-Mapped Cache with Victim Buffer

This block is the lookup and fill controller for a small read-only cache. The main store is direct-mapped: the low bits of a line address choose exactly one slot, and the remaining bits form the tag kept in that slot. A small fully associative victim buffer sits beside it. Whenever a valid line is pushed out of its slot, that line goes into the victim buffer. The buffer therefore gives extra associativity to the few sets that keep evicting each other.

A processor read is taken in through a valid/ready port. The cycle after acceptance, the slot tag and every victim entry are compared in parallel. A hit in the main slot returns the stored line. A hit in the victim buffer returns the buffered line and swaps it with the slot's current occupant. A request goes to the next level only when both structures miss. The returned line is then installed in the slot and forwarded to the processor at the same time. Only one request is in flight at a time.

Top module: `vcache_top`

## Requirements
- R1: After reset the processor port is ready, no response or next-level request is active, and every line is invalid, so the first access to any address misses.
- R2: A request is accepted on a cycle with reqValid and reqReady both high. reqReady stays low from acceptance until the cycle after the response, so only one request is outstanding.
- R3: A line address splits into an index (its low IDX_W bits) and a tag (the upper bits). A hit in the main slot raises rspValid in the cycle after acceptance with the stored line, and no next-level request is issued.
- R4: Addresses with different index bits occupy different slots and do not displace each other.
- R5: A valid line displaced from its slot by a fill is placed in the victim buffer. A later access to it is served without a next-level request, and no address is held twice in the buffer.
- R6: A victim-buffer hit raises rspValid in the cycle after acceptance with the buffered line. The line moves back into its slot, and the slot's previous line takes the freed victim entry. Both lines then hit without a next-level request.
- R7: A miss in both structures raises memReqValid with memReqAddr equal to the requested line address. Both stay unchanged until memReqReady is seen high.
- R8: After the next-level request is taken, fillReady is high until fillValid arrives. In that cycle rspValid is high and rspData equals fillData. The line is installed, so a repeat access hits.
- R9: When all VB_DEPTH victim entries are in use, a newly displaced line overwrites the entry that was filled earliest, in first-in first-out order.
- R10: rspValid is high for exactly one cycle per accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Processor read request valid |
| reqReady | output | 1 | Block can accept a request |
| reqAddr | input | ADDR_W | Requested line address |
| rspValid | output | 1 | Response strobe, one cycle |
| rspData | output | LINE_W | Returned line |
| memReqValid | output | 1 | Next-level read request valid |
| memReqReady | input | 1 | Next level accepts the request |
| memReqAddr | output | ADDR_W | Line address sent to the next level |
| fillValid | input | 1 | Fill line from the next level valid |
| fillReady | output | 1 | Block is waiting for a fill |
| fillData | input | LINE_W | Fill line |

## Verification
The bench builds the block with 8-bit line addresses, four sets, 32-bit lines and a four-entry victim buffer. With only four sets, a handful of addresses that share one index fill the buffer quickly. This makes it possible to check swaps, exclusivity between the two structures and first-in first-out overwrite in only a few dozen accesses. The next level deliberately stalls its ready and its fill for a cycle, so that the hold rule on the request and the waiting state can be seen.

// File: rtl/vcache_pkg.sv
package vcache_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LOOKUP = 2'd1,
    ST_REQ    = 2'd2,
    ST_FILL   = 2'd3
  } ctrlState_t;

  // Strobes from control to datapath
  typedef struct packed {
    logic captureAddr;  // latch incoming request address
    logic swapLine;     // exchange slot line with victim entry
    logic fillLine;     // install fill line, spill old occupant
  } ctrlStrobes_t;

endpackage

// File: rtl/vcache_victim_buf.sv
module vcache_victim_buf #(
  parameter int ADDR_W = 8,
  parameter int LINE_W = 32,
  parameter int DEPTH  = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookupAddr,
  output logic              hit,
  output logic [LINE_W-1:0] hitData,
  input  logic              insertEn,
  input  logic [ADDR_W-1:0] insertAddr,
  input  logic [LINE_W-1:0] insertData,
  input  logic              swapEn,
  input  logic [ADDR_W-1:0] swapAddr,
  input  logic [LINE_W-1:0] swapData
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

  logic [DEPTH-1:0]  entValid;
  logic [ADDR_W-1:0] entAddr [DEPTH];
  logic [LINE_W-1:0] entData [DEPTH];
  logic [DEPTH-1:0]  matchVec;
  logic [PTR_W-1:0]  hitIdx;
  logic [PTR_W-1:0]  wrPtr;

  for (genvar e = 0; e < DEPTH; e++) begin : g_match
    assign matchVec[e] = entValid[e] && (entAddr[e] == lookupAddr);
  end

  always_comb begin
    hitIdx  = '0;
    hitData = '0;
    for (int e = 0; e < DEPTH; e++) begin
      if (matchVec[e]) begin
        hitIdx  = PTR_W'(e);
        hitData = entData[e];
      end
    end
  end

  assign hit = |matchVec;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      wrPtr    <= '0;
    end else if (insertEn) begin
      entValid[wrPtr] <= 1'b1;
      wrPtr <= (wrPtr == PTR_W'(DEPTH-1)) ? '0 : wrPtr + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (insertEn) begin
      entAddr[wrPtr] <= insertAddr;
      entData[wrPtr] <= insertData;
    end else if (swapEn) begin
      entAddr[hitIdx] <= swapAddr;
      entData[hitIdx] <= swapData;
    end
  end

  // R5: an address is never buffered twice
  assert_unique_entry_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(matchVec));

  // R6: a swap only happens on a buffer hit, never with an insert
  assert_swap_needs_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    swapEn |-> (hit && !insertEn));

endmodule

// File: rtl/vcache_ctrl.sv
module vcache_ctrl
  import vcache_pkg::*;
(
  input  logic         clk,
  input  logic         rstN,
  input  logic         reqValid,
  output logic         reqReady,
  output logic         rspValid,
  output logic         memReqValid,
  input  logic         memReqReady,
  input  logic         fillValid,
  output logic         fillReady,
  input  logic         mainHit,
  input  logic         vbHit,
  output ctrlStrobes_t strb
);

  ctrlState_t state, stateNext;

  always_comb begin
    stateNext = state;
    unique case (state)
      ST_IDLE:   if (reqValid) stateNext = ST_LOOKUP;
      ST_LOOKUP: stateNext = (mainHit || vbHit) ? ST_IDLE : ST_REQ;
      ST_REQ:    if (memReqReady) stateNext = ST_FILL;
      ST_FILL:   if (fillValid) stateNext = ST_IDLE;
      default:   stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= stateNext;
  end

  assign reqReady    = (state == ST_IDLE);
  assign memReqValid = (state == ST_REQ);
  assign fillReady   = (state == ST_FILL);

  always_comb begin
    strb             = '0;
    strb.captureAddr = (state == ST_IDLE) && reqValid;
    strb.swapLine    = (state == ST_LOOKUP) && !mainHit && vbHit;
    strb.fillLine    = (state == ST_FILL) && fillValid;
  end

  assign rspValid = ((state == ST_LOOKUP) && (mainHit || vbHit)) || strb.fillLine;

  // R10: response is a single-cycle pulse
  assert_rsp_pulse_R10: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> !rspValid);

  // R2: port reopens right after a response
  assert_ready_after_rsp_R2: assert property (@(posedge clk) disable iff (!rstN)
    rspValid |=> reqReady);

  // R7: request raised only after both lookups missed
  assert_miss_before_req_R7: assert property (@(posedge clk) disable iff (!rstN)
    $rose(memReqValid) |-> $past(!mainHit && !vbHit));

  // R7: request held until taken
  assert_req_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> memReqValid);

endmodule

// File: rtl/vcache_datapath.sv
module vcache_datapath
  import vcache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 2,
  parameter int LINE_W   = 32,
  parameter int VB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  ctrlStrobes_t      strb,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic [LINE_W-1:0] fillData,
  output logic              mainHit,
  output logic              vbHit,
  output logic [LINE_W-1:0] rspData,
  output logic [ADDR_W-1:0] memReqAddr
);

  localparam int SETS  = 1 << IDX_W;
  localparam int TAG_W = ADDR_W - IDX_W;

  logic [ADDR_W-1:0] addrQ;
  logic [SETS-1:0]   mainValid;
  logic [TAG_W-1:0]  mainTag  [SETS];
  logic [LINE_W-1:0] mainData [SETS];

  logic [IDX_W-1:0]  curIdx;
  logic [TAG_W-1:0]  curTag;
  logic [ADDR_W-1:0] oldAddr;
  logic [LINE_W-1:0] oldData;
  logic [LINE_W-1:0] vbData;
  logic              spillEn;

  assign curIdx  = addrQ[IDX_W-1:0];
  assign curTag  = addrQ[ADDR_W-1:IDX_W];
  assign oldAddr = {mainTag[curIdx], curIdx};
  assign oldData = mainData[curIdx];
  assign mainHit = mainValid[curIdx] && (mainTag[curIdx] == curTag);
  assign spillEn = strb.fillLine && mainValid[curIdx];

  always_ff @(posedge clk) begin
    if (!rstN)                 addrQ <= '0;
    else if (strb.captureAddr) addrQ <= reqAddr;
  end

  always_ff @(posedge clk) begin
    if (!rstN)              mainValid <= '0;
    else if (strb.fillLine) mainValid[curIdx] <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (strb.fillLine) begin
      mainTag[curIdx]  <= curTag;
      mainData[curIdx] <= fillData;
    end else if (strb.swapLine) begin
      mainTag[curIdx]  <= curTag;
      mainData[curIdx] <= vbData;
    end
  end

  vcache_victim_buf #(
    .ADDR_W(ADDR_W),
    .LINE_W(LINE_W),
    .DEPTH (VB_DEPTH)
  ) u_vbuf (
    .clk       (clk),
    .rstN      (rstN),
    .lookupAddr(addrQ),
    .hit       (vbHit),
    .hitData   (vbData),
    .insertEn  (spillEn),
    .insertAddr(oldAddr),
    .insertData(oldData),
    .swapEn    (strb.swapLine),
    .swapAddr  (oldAddr),
    .swapData  (oldData)
  );

  always_comb begin
    if (strb.fillLine)  rspData = fillData;
    else if (mainHit)   rspData = oldData;
    else                rspData = vbData;
  end

  assign memReqAddr = addrQ;

  // R6: a line lives in the slot or the buffer, never both
  assert_no_dual_hit_R6: assert property (@(posedge clk) disable iff (!rstN)
    !(mainHit && vbHit));

  // R8: a fill leaves the slot valid
  assert_fill_installs_R8: assert property (@(posedge clk) disable iff (!rstN)
    strb.fillLine |=> mainValid[$past(curIdx)]);

endmodule

// File: rtl/vcache_top.sv
module vcache_top
  import vcache_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int IDX_W    = 2,
  parameter int LINE_W   = 32,
  parameter int VB_DEPTH = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  output logic              reqReady,
  input  logic [ADDR_W-1:0] reqAddr,
  output logic              rspValid,
  output logic [LINE_W-1:0] rspData,
  output logic              memReqValid,
  input  logic              memReqReady,
  output logic [ADDR_W-1:0] memReqAddr,
  input  logic              fillValid,
  output logic              fillReady,
  input  logic [LINE_W-1:0] fillData
);

  ctrlStrobes_t strb;
  logic mainHit;
  logic vbHit;

  vcache_ctrl u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqReady   (reqReady),
    .rspValid   (rspValid),
    .memReqValid(memReqValid),
    .memReqReady(memReqReady),
    .fillValid  (fillValid),
    .fillReady  (fillReady),
    .mainHit    (mainHit),
    .vbHit      (vbHit),
    .strb       (strb)
  );

  vcache_datapath #(
    .ADDR_W  (ADDR_W),
    .IDX_W   (IDX_W),
    .LINE_W  (LINE_W),
    .VB_DEPTH(VB_DEPTH)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .reqAddr   (reqAddr),
    .fillData  (fillData),
    .mainHit   (mainHit),
    .vbHit     (vbHit),
    .rspData   (rspData),
    .memReqAddr(memReqAddr)
  );

  // R7: address stable while the request waits
  assert_addr_stable_R7: assert property (@(posedge clk) disable iff (!rstN)
    (memReqValid && !memReqReady) |=> $stable(memReqAddr));

  // R2: never waiting on the next level while open for requests
  assert_one_outstanding_R2: assert property (@(posedge clk) disable iff (!rstN)
    reqReady |-> (!memReqValid && !fillReady));

endmodule

// File: tb/vcache_top_bench.sv
`timescale 1ns/1ps
module vcache_top_bench;

  localparam int ADDR_W = 8;
  localparam int IDX_W  = 2;
  localparam int LINE_W = 32;
  localparam int VB_D   = 4;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [ADDR_W-1:0] reqAddr = '0;
  logic rspValid;
  logic [LINE_W-1:0] rspData;
  logic memReqValid;
  logic memReqReady = 1'b0;
  logic [ADDR_W-1:0] memReqAddr;
  logic fillValid = 1'b0;
  logic fillReady;
  logic [LINE_W-1:0] fillData = '0;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;

  vcache_top #(.ADDR_W(ADDR_W), .IDX_W(IDX_W), .LINE_W(LINE_W), .VB_DEPTH(VB_D)) u_vcache_top (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .rspValid(rspValid), .rspData(rspData),
    .memReqValid(memReqValid), .memReqReady(memReqReady), .memReqAddr(memReqAddr),
    .fillValid(fillValid), .fillReady(fillReady), .fillData(fillData)
  );

  function automatic logic [LINE_W-1:0] lineOf(input logic [ADDR_W-1:0] a);
    return {8'hA5, a, ~a, a ^ 8'h3C};
  endfunction

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; reqValid = 1'b0; memReqReady = 1'b0; fillValid = 1'b0;
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    #1;
  endtask

  // One complete read; expHit says whether no next-level request is expected
  task automatic access(input logic [ADDR_W-1:0] a, input bit expHit, input string req);
    bit gotHit;
    @(negedge clk);
    check(reqReady == 1'b1, "R2", "ready before request", reqReady, 1);
    reqValid = 1'b1; reqAddr = a;
    @(negedge clk);
    reqValid = 1'b0;
    #1;
    gotHit = rspValid;
    check(gotHit == expHit, req, $sformatf("hit flag for %0h", a), gotHit, expHit);
    if (gotHit) begin
      check(rspData == lineOf(a), req, "hit data", rspData, lineOf(a));
      check(memReqValid == 1'b0, req, "no request on hit", memReqValid, 0);
    end else begin
      check(reqReady == 1'b0, "R2", "ready low during miss", reqReady, 0);
      @(negedge clk); #1;
      check(memReqValid == 1'b1 && memReqAddr == a, "R7", "request raised",
            {memReqValid, memReqAddr}, {1'b1, a});
      @(negedge clk); #1;
      check(memReqValid == 1'b1 && memReqAddr == a, "R7", "request held",
            {memReqValid, memReqAddr}, {1'b1, a});
      memReqReady = 1'b1;
      @(negedge clk);
      memReqReady = 1'b0;
      #1;
      check(fillReady == 1'b1 && rspValid == 1'b0, "R8", "waiting for fill",
            {fillReady, rspValid}, 2'b10);
      @(negedge clk);
      fillValid = 1'b1; fillData = lineOf(a);
      #1;
      check(rspValid == 1'b1 && rspData == lineOf(a), "R8", "fill forwarded",
            rspData, lineOf(a));
    end
    @(negedge clk);
    fillValid = 1'b0;
    #1;
    check(rspValid == 1'b0, "R10", "response one cycle", rspValid, 0);
    check(reqReady == 1'b1, "R2", "ready after response", reqReady, 1);
  endtask

  task automatic testReset();
    doReset();
    check(reqReady == 1'b1 && rspValid == 1'b0 && memReqValid == 1'b0 && fillReady == 1'b0,
          "R1", "idle after reset", {reqReady, rspValid, memReqValid, fillReady}, 4'b1000);
    access(8'h10, 1'b0, "R1");
  endtask

  task automatic testFillThenHit();
    access(8'h10, 1'b1, "R3");
    access(8'h11, 1'b0, "R8");
    access(8'h11, 1'b1, "R8");
    access(8'h10, 1'b1, "R4");
  endtask

  task automatic testSwap();
    access(8'h14, 1'b0, "R5");   // displaces 0x10 into the buffer
    access(8'h10, 1'b1, "R5");   // buffer hit, swap
    access(8'h14, 1'b1, "R6");   // displaced line now in buffer
    access(8'h10, 1'b1, "R6");
    access(8'h11, 1'b1, "R4");
  endtask

  task automatic testFifo();
    doReset();
    access(8'h02, 1'b0, "R9");
    access(8'h06, 1'b0, "R9");
    access(8'h0A, 1'b0, "R9");
    access(8'h0E, 1'b0, "R9");
    access(8'h12, 1'b0, "R9");   // buffer full: 02 06 0A 0E
    access(8'h16, 1'b0, "R9");   // 12 overwrites 02
    access(8'h02, 1'b0, "R9");   // oldest was dropped; 16 overwrites 06
    access(8'h0A, 1'b1, "R9");   // still buffered
    access(8'h06, 1'b0, "R9");   // overwritten second
    access(8'h0E, 1'b1, "R5");
  endtask

  initial begin
    testReset();
    testFillThenHit();
    testSwap();
    testFifo();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

endmodule